// File: doc/BRIEF.md
# Master FIFO and Interrupt Unit

This block sits between a word-addressed register port and the serial transfer engine of a two-wire bus controller. It holds a transmit byte queue that software fills and the engine drains, and a receive byte queue that the engine fills and software drains. A FIFO control register sets a receive high-water threshold and a low threshold, and has a self-clearing bit that flushes both queues. A word-count register reports how full the receive queue is.

Hardware events from the engine, plus queue events raised here, set bits in an interrupt status register. Software clears a status bit by writing a one to it. An enable register selects which status bits drive the single level-sensitive interrupt output. That output is registered.

Register reads return data one cycle after the request. A read of the receive data offset pops one byte. A write to the transmit data offset pushes the low byte of the write data. Offsets that belong to other parts of the controller (divider, control, command, address) read as zero here.

Top module: `mfifo_irq_unit`

## Requirements
- R1: After reset both queues are empty, and the status, enable, threshold fields and irq_o are all zero.
- R2: Bytes written to offset 0x4 come out on tx_data_o in write order, one per tx_pop_i pulse. The queue holds 128 bytes. tx_data_o reads zero while the transmit queue is empty.
- R3: Bytes pushed with rx_push_i are returned in order by reads of offset 0x5. A read of an empty receive queue returns zero and leaves the occupancy at zero.
- R4: A read of offset 0xC returns the receive occupancy in bits 7:0 and zero in all other bits.
- R5: Offset 0x6 holds the high threshold in bits 15:8 and the low threshold in bits 7:0, and both read back. Writing a one to bit 16 empties both queues. Bit 16 always reads as zero.
- R6: A push to a full queue, from either side, is dropped and sets status bit 4.
- R7: Status bit 2 is set in every cycle where the receive occupancy is at least the high threshold and the threshold is nonzero.
- R8: Status bit 3 is set when the transmit occupancy falls from nonzero to zero while wr_active_i is high, and not when wr_active_i is low.
- R9: The event inputs set these status bits: ev_nack_i sets bit 25, ev_sack_i sets bit 13, ev_done_i sets bit 12, ev_arb_i sets bit 11 and ev_berr_i sets bit 0. The status register at 0xE reads zero when no event is pending.
- R10: A write to offset 0xE clears every status bit that has a one in the write data. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R11: The enable register at 0xD keeps only the eight implemented status positions. irq_o goes high one cycle after a status bit is set together with its enable bit, and it is zero when no enabled bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the request |
| tx_data_o | output | 8 | Head of the transmit queue, zero when empty |
| tx_pop_i | input | 1 | Engine takes one transmit byte |
| rx_data_i | input | 8 | Received byte from the engine |
| rx_push_i | input | 1 | Engine stores one received byte |
| wr_active_i | input | 1 | A write transfer is in progress |
| ev_nack_i | input | 1 | Address not acknowledged |
| ev_sack_i | input | 1 | Slave address acknowledged |
| ev_done_i | input | 1 | Data phase complete |
| ev_arb_i | input | 1 | Arbitration lost |
| ev_berr_i | input | 1 | Bus error |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The threshold logic is swept over high-threshold values 0, 1, 3, 64 and 128. For each value the receive queue grows one byte at a time, from empty to past full. After every step the status is cleared and read back, together with the word count. This separates the at-or-above comparison from a strictly-above one, shows that a zero threshold never fires, and shows that the count stops at 128. Each queue is filled with an arithmetic byte pattern to capacity plus one. The overflow status and the order of the bytes that come out tell a dropped push apart from an overwrite. Each event input is pulsed on its own and the whole status word is compared, which catches a bit landing in the wrong position. The empty event is tried both with and without an active write transfer. The clear-versus-set collision is driven in a single cycle.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFF_TXD  = 5'h04;
  localparam logic [AW-1:0] OFF_RXD  = 5'h05;
  localparam logic [AW-1:0] OFF_FCTL = 5'h06;
  localparam logic [AW-1:0] OFF_WCNT = 5'h0C;
  localparam logic [AW-1:0] OFF_IEN  = 5'h0D;
  localparam logic [AW-1:0] OFF_IST  = 5'h0E;

  localparam int unsigned B_NACK  = 25;
  localparam int unsigned B_SACK  = 13;
  localparam int unsigned B_DONE  = 12;
  localparam int unsigned B_ARB   = 11;
  localparam int unsigned B_FULL  = 4;
  localparam int unsigned B_EMPTY = 3;
  localparam int unsigned B_HI    = 2;
  localparam int unsigned B_BERR  = 0;

  localparam int unsigned FLUSH_BIT = 16;

  localparam logic [DW-1:0] IRQ_MASK =
    (32'd1 << B_NACK) | (32'd1 << B_SACK) | (32'd1 << B_DONE) | (32'd1 << B_ARB) |
    (32'd1 << B_FULL) | (32'd1 << B_EMPTY) | (32'd1 << B_HI) | (32'd1 << B_BERR);
endpackage

// File: rtl/mfu_byte_fifo.sv
module mfu_byte_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign drop_o  = push_i && full && !flush_i;
  assign count_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem[rd_ptr_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r6_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i) |=> count_o == CW'(DEPTH));
  a_r3_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
  a_r5_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/mfu_irq_regs.sv
module mfu_irq_regs
  import mfu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic [DW-1:0] en_wdata_i,
  output logic [DW-1:0] sts_o,
  output logic [DW-1:0] en_o,
  output logic          irq_o
);
  logic [DW-1:0] sts_q, en_q, set_m;
  logic          irq_q;

  assign set_m = set_i & IRQ_MASK;
  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_m;  // set wins over clear
      if (en_wr_i) en_q <= en_wdata_i & IRQ_MASK;
      irq_q <= |(sts_q & en_q);
    end
  end

  a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i != '0) && ((set_m & clr_i) == '0)) |=> (sts_q & $past(clr_i)) == '0);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m != '0) |=> (sts_q & $past(set_m)) == $past(set_m));
  a_r11_irq_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_q & en_q)) |=> irq_o);
  a_r11_irq_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sts_q & en_q)) |=> !irq_o);
endmodule

// File: rtl/mfifo_irq_unit.sv
module mfifo_irq_unit
  import mfu_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned TH_W       = 8,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_pop_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_push_i,
  input  logic          wr_active_i,
  input  logic          ev_nack_i,
  input  logic          ev_sack_i,
  input  logic          ev_done_i,
  input  logic          ev_arb_i,
  input  logic          ev_berr_i,
  output logic          irq_o
);
  logic            wr, rd, flush;
  logic [TH_W-1:0] hi_th_q, lo_th_q;
  logic [7:0]      rx_head;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_empty, rx_empty, tx_empty_q, tx_drop, rx_drop;
  logic            ev_empty, ev_hi;
  logic [DW-1:0]   set_v, clr_v, sts, en, rdata_q;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign flush = wr && (addr_i == OFF_FCTL) && wdata_i[FLUSH_BIT];

  mfu_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(wr && addr_i == OFF_TXD), .wdata_i(wdata_i[7:0]),
    .pop_i(tx_pop_i), .rdata_o(tx_data_o), .count_o(tx_cnt),
    .empty_o(tx_empty), .drop_o(tx_drop)
  );

  mfu_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push_i), .wdata_i(rx_data_i),
    .pop_i(rd && addr_i == OFF_RXD), .rdata_o(rx_head), .count_o(rx_cnt),
    .empty_o(rx_empty), .drop_o(rx_drop)
  );

  assign ev_empty = wr_active_i && tx_empty && !tx_empty_q;
  assign ev_hi    = (hi_th_q != '0) && (32'(rx_cnt) >= 32'(hi_th_q));

  always_comb begin
    set_v          = '0;
    set_v[B_NACK]  = ev_nack_i;
    set_v[B_SACK]  = ev_sack_i;
    set_v[B_DONE]  = ev_done_i;
    set_v[B_ARB]   = ev_arb_i;
    set_v[B_FULL]  = tx_drop || rx_drop;
    set_v[B_EMPTY] = ev_empty;
    set_v[B_HI]    = ev_hi;
    set_v[B_BERR]  = ev_berr_i;
    clr_v = (wr && addr_i == OFF_IST) ? wdata_i : '0;
  end

  mfu_irq_regs u_irq (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v),
    .en_wr_i(wr && addr_i == OFF_IEN), .en_wdata_i(wdata_i),
    .sts_o(sts), .en_o(en), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_th_q    <= '0;
      lo_th_q    <= '0;
      tx_empty_q <= 1'b1;
      rdata_q    <= '0;
    end else begin
      tx_empty_q <= tx_empty;
      if (wr && addr_i == OFF_FCTL) begin
        hi_th_q <= wdata_i[8 +: TH_W];
        lo_th_q <= wdata_i[0 +: TH_W];
      end
      if (rd) begin
        case (addr_i)
          OFF_RXD:  rdata_q <= DW'(rx_head);
          OFF_FCTL: rdata_q <= DW'({hi_th_q, lo_th_q});
          OFF_WCNT: rdata_q <= DW'(rx_cnt);
          OFF_IEN:  rdata_q <= en;
          OFF_IST:  rdata_q <= sts;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;

  a_r7_hi_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hi_th_q != '0) && (32'(rx_cnt) >= 32'(hi_th_q))) |=> sts[B_HI]);
  a_r8_empty_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_active_i && tx_empty && !tx_empty_q) |=> sts[B_EMPTY]);
  a_r3_rx_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFF_RXD && rx_empty) |=> rdata_o == '0);
endmodule

// File: tb/sim_mfifo_irq_unit.sv
`timescale 1ns/1ps
module sim_mfifo_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tx_data;
  logic        tx_pop = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_push = 1'b0, wr_active = 1'b0;
  logic        ev_nack = 1'b0, ev_sack = 1'b0, ev_done = 1'b0, ev_arb = 1'b0, ev_berr = 1'b0;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mfifo_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_data_o(tx_data), .tx_pop_i(tx_pop),
    .rx_data_i(rx_data), .rx_push_i(rx_push), .wr_active_i(wr_active),
    .ev_nack_i(ev_nack), .ev_sack_i(ev_sack), .ev_done_i(ev_done),
    .ev_arb_i(ev_arb), .ev_berr_i(ev_berr), .irq_o(irq)
  );

  task automatic chk(input string req_s, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req_s, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rx_in(input logic [7:0] d);
    rx_push = 1'b1; rx_data = d;
    @(posedge clk); @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic tx_take();
    tx_pop = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 7 + s) & 8'hFF);
  endfunction

  localparam logic [31:0] MASK = 32'h0200_381D;

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(5'h0E, d); chk("R1 status", d, 32'h0);
    rd_reg(5'h0D, d); chk("R1 enable", d, 32'h0);
    rd_reg(5'h06, d); chk("R1 fifo ctrl", d, 32'h0);
    rd_reg(5'h0C, d); chk("R1 word count", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx head", {24'b0, tx_data}, 32'h0);

    // R5 thresholds read back, flush bit reads zero
    wr_reg(5'h06, 32'h0001_235A);
    rd_reg(5'h06, d); chk("R5 fctl readback", d, 32'h0000_235A);

    // R3 empty read
    rd_reg(5'h05, d); chk("R3 empty read", d, 32'h0);
    rd_reg(5'h0C, d); chk("R3 empty count", d, 32'h0);

    // R2 / R6 transmit fill to capacity + 1
    wr_reg(5'h0E, 32'hFFFF_FFFF);
    for (int i = 0; i < 129; i++) wr_reg(5'h04, {24'b0, pat(i, 3)});
    idle(1);
    rd_reg(5'h0E, d); chk("R6 tx overflow bit4", d & 32'h10, 32'h10);
    for (int i = 0; i < 128; i++) begin
      chk("R2 tx order", {24'b0, tx_data}, {24'b0, pat(i, 3)});
      tx_take();
    end
    chk("R2 tx empty head zero", {24'b0, tx_data}, 32'h0);

    // R8 empty event with write active
    wr_reg(5'h0E, 32'hFFFF_FFFF);
    wr_active = 1'b1;
    wr_reg(5'h04, 32'h11); wr_reg(5'h04, 32'h22);
    tx_take(); idle(2);
    rd_reg(5'h0E, d); chk("R8 no event at nonzero", d & 32'h8, 32'h0);
    tx_take(); idle(2);
    rd_reg(5'h0E, d); chk("R8 empty event active", d & 32'h8, 32'h8);
    wr_active = 1'b0;
    wr_reg(5'h0E, 32'hFFFF_FFFF);
    wr_reg(5'h04, 32'h33); tx_take(); idle(2);
    rd_reg(5'h0E, d); chk("R8 no event when inactive", d & 32'h8, 32'h0);

    // R3 / R6 receive fill to capacity + 1
    wr_reg(5'h0E, 32'hFFFF_FFFF);
    for (int i = 0; i < 129; i++) rx_in(pat(i, 11));
    idle(1);
    rd_reg(5'h0E, d); chk("R6 rx overflow bit4", d & 32'h10, 32'h10);
    rd_reg(5'h0C, d); chk("R4 full count", d, 32'd128);
    for (int i = 0; i < 128; i++) begin
      rd_reg(5'h05, d); chk("R3 rx order", d, {24'b0, pat(i, 11)});
    end
    rd_reg(5'h0C, d); chk("R4 drained count", d, 32'd0);

    // R5 flush empties both queues
    for (int i = 0; i < 5; i++) begin rx_in(8'(i)); wr_reg(5'h04, 32'(i + 1)); end
    wr_reg(5'h06, 32'h0001_0000);
    rd_reg(5'h0C, d); chk("R5 flush rx", d, 32'h0);
    chk("R5 flush tx", {24'b0, tx_data}, 32'h0);

    // R7 / R4 threshold sweep
    for (int k = 0; k < 5; k++) begin
      int hi;
      case (k)
        0: hi = 0;
        1: hi = 1;
        2: hi = 3;
        3: hi = 64;
        default: hi = 128;
      endcase
      wr_reg(5'h06, 32'h0001_0000 | (32'(hi) << 8));
      for (int n = 1; n <= 130; n++) begin
        int occ;
        occ = (n > 128) ? 128 : n;
        rx_in(8'(n));
        wr_reg(5'h0E, 32'h4);
        rd_reg(5'h0E, d);
        chk("R7 threshold bit2", d & 32'h4, (hi != 0 && occ >= hi) ? 32'h4 : 32'h0);
        rd_reg(5'h0C, d); chk("R4 sweep count", d, 32'(occ));
      end
    end
    wr_reg(5'h06, 32'h0001_0000);
    wr_reg(5'h0E, 32'hFFFF_FFFF);
    idle(1);
    rd_reg(5'h0E, d); chk("R9 status zero when idle", d, 32'h0);

    // R9 event mapping, one at a time
    for (int e = 0; e < 5; e++) begin
      logic [31:0] exp;
      case (e)
        0: begin ev_nack = 1'b1; exp = 32'h0200_0000; end
        1: begin ev_sack = 1'b1; exp = 32'h0000_2000; end
        2: begin ev_done = 1'b1; exp = 32'h0000_1000; end
        3: begin ev_arb  = 1'b1; exp = 32'h0000_0800; end
        default: begin ev_berr = 1'b1; exp = 32'h0000_0001; end
      endcase
      @(posedge clk); @(negedge clk);
      ev_nack = 0; ev_sack = 0; ev_done = 0; ev_arb = 0; ev_berr = 0;
      rd_reg(5'h0E, d); chk("R9 event bit", d, exp);
      wr_reg(5'h0E, exp);
      rd_reg(5'h0E, d); chk("R10 w1c clears", d, 32'h0);
    end

    // R10 partial clear and set-wins collision
    ev_done = 1'b1; ev_arb = 1'b1;
    @(posedge clk); @(negedge clk);
    ev_done = 1'b0; ev_arb = 1'b0;
    wr_reg(5'h0E, 32'h0000_0800);
    rd_reg(5'h0E, d); chk("R10 partial clear", d, 32'h0000_1000);
    req = 1'b1; we = 1'b1; addr = 5'h0E; wdata = 32'h0000_1000; ev_done = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0; ev_done = 1'b0;
    rd_reg(5'h0E, d); chk("R10 set wins", d, 32'h0000_1000);
    wr_reg(5'h0E, 32'hFFFF_FFFF);

    // R11 enable mask and irq timing
    wr_reg(5'h0D, 32'hFFFF_FFFF);
    rd_reg(5'h0D, d); chk("R11 enable mask", d, MASK);
    wr_reg(5'h0D, 32'h0000_0001);
    ev_arb = 1'b1;
    @(posedge clk); @(negedge clk);
    ev_arb = 1'b0;
    idle(2);
    chk("R11 disabled bit no irq", {31'b0, irq}, 32'h0);
    ev_berr = 1'b1;
    @(posedge clk); @(negedge clk);
    ev_berr = 1'b0;
    chk("R11 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 irq raised", {31'b0, irq}, 32'h1);
    wr_reg(5'h0E, 32'h1);
    idle(1);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule